// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Bank with Overflow Interrupt

This block holds a bank of programmable 64-bit event counters for a processor core. Each counter advances by one in every cycle in which its increment strobe is high, unless one of three things blocks it: the counter is not usable, its bit in the global inhibit vector is set, or its own mode-filter bit for the current privilege level and virtualization state is set. Counter indices 0, 1 and 2 belong to fixed counters outside this bank and never count here. The `AVAIL_MASK` parameter marks which of the remaining indices are implemented.

When a counter wraps from all ones to zero and its sticky overflow flag is clear, the flag is set and the shared local overflow interrupt request goes high. A wrap while the flag is already set changes nothing beyond the count. Software clears the flag with a selector write and drops the interrupt request with a clear pulse. In 32-bit mode each counter is written as two halves, and the filter and overflow bits are taken from the upper selector word. In that mode the low half stops at all ones while the high half advances. The counter wraps only when both halves are all ones.

All pins are plain control and status signals, so there is no valid/ready handshake. Register writes take effect at the next clock edge. The read port is combinational.

Top module: `pmu_ovf_bank`

## Requirements
- R1: After reset every counter reads zero, every selector reads zero and `irq_o` is low.
- R2: A usable counter whose inhibit bit and mode-filter bit are both clear rises by exactly one at each clock edge where its `inc_i` bit is high, and it holds its value otherwise.
- R3: A counter is usable when its index is 3 or more and its `AVAIL_MASK` bit is set. A counter that is not usable never counts, ignores writes and reads zero. A usable counter whose `inhibit_i` bit is set holds its value.
- R4: Privilege is encoded on `priv_i` as 0 for user, 1 for supervisor and 3 for machine. Code 2 has no filter. The selector bits in `rd_sel_o` are [4] machine, [3] supervisor with `virt_i`=0, [2] user with `virt_i`=0, [1] supervisor with `virt_i`=1 and [0] user with `virt_i`=1. A set bit stops counting only in its own mode.
- R5: In 64-bit mode, an increment of an all-ones counter makes it zero. If the counter's overflow flag (`rd_sel_o[5]`) was clear, the flag is set and `irq_o` goes high one edge later.
- R6: A wrap while the overflow flag is already set leaves the flag set and does not raise `irq_o`.
- R7: In 32-bit mode, the low half increments unless it is all ones. If the low half is all ones and the high half is not, only the high half increments. Only when both halves are all ones does the counter become zero, with overflow handled as in R5 and R6.
- R8: Write kinds on `wr_kind_i` are 2 (selector, 64-bit) and 3 (selector upper word, 32-bit). In 64-bit mode only kind 2 changes a selector, taking bits [63:58] as overflow, machine, supervisor, user, virtual supervisor and virtual user. In 32-bit mode only kind 3 does this, taking the same order from bits [31:26]. The kind that does not match the mode has no effect.
- R9: The overflow flag is cleared only by a selector write. `irq_o` stays high until `irq_clr_i` is high at an edge. A new overflow in that same cycle keeps `irq_o` high.
- R10: A counter write to a counter in the same cycle as an increment of that counter loads the written value, and the increment is lost.
- R11: Write kind 0 loads the whole counter in 64-bit mode and only the low 32 bits in 32-bit mode. Write kind 1 loads the high 32 bits from `wr_data_i[31:0]` in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inc_i | input | N_CTR | Per-counter increment strobes |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Virtualization active |
| inhibit_i | input | N_CTR | Global per-counter inhibit bits |
| mode32_i | input | 1 | 32-bit register view |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | 0 counter/low, 1 counter high, 2 selector, 3 selector upper |
| wr_idx_i | input | $clog2(N_CTR) | Counter index of the write |
| wr_data_i | input | CTR_W | Write data |
| irq_clr_i | input | 1 | Clears the interrupt request |
| rd_idx_i | input | $clog2(N_CTR) | Counter index to read |
| rd_cnt_o | output | CTR_W | Value of the selected counter |
| rd_sel_o | output | 6 | Overflow flag and filter bits of the selected counter |
| irq_o | output | 1 | Local counter overflow interrupt request |

## Verification
Directed runs step each single filter bit through all five privilege/virtualization combinations, so a swapped pair of filter bits shows up as the wrong mode blocking. Counters are preloaded at all ones, and at the 32-bit boundary values with the low half full and the high half below or at full. These separate the plain wrap, the high-half-only carry and the double-full wrap, and a second wrap with the flag still set separates first-overflow signalling from every-overflow signalling. Same-cycle write-and-increment and set-versus-clear of the interrupt pin down the priorities. A seeded random run then mixes strobes, modes, inhibit bits, near-overflow writes and clears in both register views against a bench model.

// File: rtl/pmu_ovf_pkg.sv
package pmu_ovf_pkg;

  typedef enum logic [1:0] {
    WR_CNT    = 2'd0,
    WR_CNT_HI = 2'd1,
    WR_SEL    = 2'd2,
    WR_SEL_HI = 2'd3
  } wr_kind_e;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  // Selector bits kept per counter, msb first as they sit in the register word.
  typedef struct packed {
    logic ovf;
    logic m_off;
    logic s_off;
    logic u_off;
    logic vs_off;
    logic vu_off;
  } evsel_t;

  localparam int SEL_W      = $bits(evsel_t);
  localparam int FIRST_PROG = 3;

endpackage

// File: rtl/pmu_mode_filter.sv
module pmu_mode_filter
  import pmu_ovf_pkg::*;
(
  input  evsel_t     sel,
  input  logic [1:0] priv,
  input  logic       virt,
  output logic       blocked
);

  always_comb begin
    unique case (priv_e'(priv))
      PRIV_M:  blocked = sel.m_off;
      PRIV_S:  blocked = virt ? sel.vs_off : sel.s_off;
      PRIV_U:  blocked = virt ? sel.vu_off : sel.u_off;
      default: blocked = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmu_ctr_slice.sv
module pmu_ctr_slice
  import pmu_ovf_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump,
  input  logic          mode32,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  evsel_t        sel_wdata,
  output logic [CW-1:0] cnt_o,
  output evsel_t        sel_o,
  output logic          ovf_new_o
);

  localparam int HW = CW / 2;

  logic [CW-1:0] cnt_q, cnt_inc;
  evsel_t        sel_q, sel_d;
  logic          wrap;
  logic [HW-1:0] lo, hi;

  assign lo = cnt_q[HW-1:0];
  assign hi = cnt_q[CW-1:HW];

  // Next value when counting, in the register view chosen by mode32.
  always_comb begin
    cnt_inc = cnt_q;
    wrap    = 1'b0;
    if (mode32) begin
      if (&lo) begin
        if (&hi) begin
          cnt_inc = '0;
          wrap    = 1'b1;
        end else begin
          cnt_inc[CW-1:HW] = hi + HW'(1);
        end
      end else begin
        cnt_inc[HW-1:0] = lo + HW'(1);
      end
    end else if (&cnt_q) begin
      cnt_inc = '0;
      wrap    = 1'b1;
    end else begin
      cnt_inc = cnt_q + CW'(1);
    end
  end

  assign ovf_new_o = bump & wrap & ~sel_q.ovf;

  always_comb begin
    sel_d = wr_sel ? sel_wdata : sel_q;
    if (ovf_new_o) sel_d.ovf = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
      if (wr_lo) begin
        if (mode32) cnt_q[HW-1:0] <= wr_data[HW-1:0];
        else        cnt_q         <= wr_data;
      end else if (wr_hi) begin
        cnt_q[CW-1:HW] <= wr_data[HW-1:0];
      end else if (bump) begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;

endmodule

// File: rtl/pmu_ovf_bank.sv
module pmu_ovf_bank
  import pmu_ovf_pkg::*;
#(
  parameter int               N_CTR      = 8,
  parameter int               CTR_W      = 64,
  parameter logic [N_CTR-1:0] AVAIL_MASK = 8'hF8,
  localparam int              IW         = $clog2(N_CTR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CTR-1:0] inc_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic [N_CTR-1:0] inhibit_i,
  input  logic             mode32_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_kind_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [CTR_W-1:0] wr_data_i,
  input  logic             irq_clr_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [CTR_W-1:0] rd_cnt_o,
  output logic [SEL_W-1:0] rd_sel_o,
  output logic             irq_o
);

  localparam int               HW        = CTR_W / 2;
  localparam logic [N_CTR-1:0] FIXED_MSK = N_CTR'((64'd1 << FIRST_PROG) - 64'd1);
  localparam logic [N_CTR-1:0] USABLE    = AVAIL_MASK & ~FIXED_MSK;

  logic [N_CTR-1:0]            blk, bump, hit, wr_lo, wr_hi, wr_sel, ovf_new;
  logic [N_CTR-1:0][CTR_W-1:0] cnt_all;
  evsel_t [N_CTR-1:0]          sel_all;
  evsel_t                      sel_wd;
  logic                        sel_kind_ok, irq_q;
  wr_kind_e                    kind;

  assign kind        = wr_kind_e'(wr_kind_i);
  assign sel_wd      = mode32_i ? wr_data_i[HW-1 -: SEL_W] : wr_data_i[CTR_W-1 -: SEL_W];
  assign sel_kind_ok = mode32_i ? (kind == WR_SEL_HI) : (kind == WR_SEL);

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    assign hit[i]    = wr_en_i & (wr_idx_i == IW'(i)) & USABLE[i];
    assign wr_lo[i]  = hit[i] & (kind == WR_CNT);
    assign wr_hi[i]  = hit[i] & (kind == WR_CNT_HI);
    assign wr_sel[i] = hit[i] & sel_kind_ok;
    // A counter write in the same cycle wins over the increment.
    assign bump[i]   = inc_i[i] & ~inhibit_i[i] & USABLE[i] & ~blk[i] & ~wr_lo[i] & ~wr_hi[i];

    pmu_mode_filter u_flt (
      .sel     (sel_all[i]),
      .priv    (priv_i),
      .virt    (virt_i),
      .blocked (blk[i])
    );

    pmu_ctr_slice #(.CW(CTR_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .bump      (bump[i]),
      .mode32    (mode32_i),
      .wr_lo     (wr_lo[i]),
      .wr_hi     (wr_hi[i]),
      .wr_sel    (wr_sel[i]),
      .wr_data   (wr_data_i),
      .sel_wdata (sel_wd),
      .cnt_o     (cnt_all[i]),
      .sel_o     (sel_all[i]),
      .ovf_new_o (ovf_new[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (|ovf_new)  irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign irq_o    = irq_q;
  assign rd_cnt_o = cnt_all[rd_idx_i];
  assign rd_sel_o = sel_all[rd_idx_i];

endmodule

// File: rtl/pmu_ovf_chk.sv
module pmu_ovf_chk
  import pmu_ovf_pkg::*;
#(
  parameter int N_CTR = 8,
  parameter int CTR_W = 64,
  localparam int IW   = $clog2(N_CTR)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_CTR-1:0]            inhibit_i,
  input logic                        wr_en_i,
  input logic [1:0]                  wr_kind_i,
  input logic [IW-1:0]               wr_idx_i,
  input logic                        irq_clr_i,
  input logic                        irq_o,
  input logic [N_CTR-1:0]            ovf_new,
  input logic [N_CTR-1:0][CTR_W-1:0] cnt_all,
  input evsel_t [N_CTR-1:0]          sel_all
);

  // R9: request held until cleared
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_clr_i |=> irq_o);

  // R5: a first overflow raises the request at the next edge
  p_irq_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_new) |=> irq_o);

  for (genvar i = 0; i < N_CTR; i++) begin : g_chk
    logic cnt_wr, sel_wr;
    assign cnt_wr = wr_en_i && (wr_idx_i == IW'(i)) && !wr_kind_i[1];
    assign sel_wr = wr_en_i && (wr_idx_i == IW'(i)) && wr_kind_i[1];

    // R3: inhibited counter keeps its value
    p_inhibit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_i[i] && !cnt_wr |=> $stable(cnt_all[i]));

    // R9: overflow flag only falls through a selector write
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_all[i].ovf && !sel_wr |=> sel_all[i].ovf);

    // R5: a first overflow leaves the flag set and the counter at zero
    p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_new[i] && !sel_wr |=> sel_all[i].ovf && (cnt_all[i] == '0));
  end

endmodule

bind pmu_ovf_bank pmu_ovf_chk #(.N_CTR(N_CTR), .CTR_W(CTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inhibit_i (inhibit_i),
  .wr_en_i   (wr_en_i),
  .wr_kind_i (wr_kind_i),
  .wr_idx_i  (wr_idx_i),
  .irq_clr_i (irq_clr_i),
  .irq_o     (irq_o),
  .ovf_new   (ovf_new),
  .cnt_all   (cnt_all),
  .sel_all   (sel_all)
);

// File: tb/test_pmu_ovf_bank.sv
`timescale 1ns/100ps
module test_pmu_ovf_bank;

  localparam int         N     = 8;
  localparam logic [7:0] AVAIL = 8'hB8;   // usable: 3,4,5,7
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  inc = '0, inhibit = '0;
  logic [1:0]  priv = 2'd3, wr_kind = '0;
  logic        virt = 1'b0, mode32 = 1'b0, wr_en = 1'b0, irq_clr = 1'b0;
  logic [2:0]  wr_idx = '0, rd_idx = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_cnt;
  logic [5:0]  rd_sel;
  logic        irq;

  logic [63:0] m_cnt [N];
  logic [5:0]  m_sel [N];
  logic        m_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pmu_ovf_bank #(.N_CTR(N), .CTR_W(64), .AVAIL_MASK(AVAIL)) i_pmu_ovf_bank (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .priv_i(priv), .virt_i(virt),
    .inhibit_i(inhibit), .mode32_i(mode32), .wr_en_i(wr_en), .wr_kind_i(wr_kind),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .irq_clr_i(irq_clr),
    .rd_idx_i(rd_idx), .rd_cnt_o(rd_cnt), .rd_sel_o(rd_sel), .irq_o(irq));

  function automatic bit usable(int i);
    return (i >= 3) && AVAIL[i];
  endfunction

  function automatic bit filt(logic [5:0] s);
    case (priv)
      2'd3:    return s[4];
      2'd1:    return virt ? s[1] : s[3];
      2'd0:    return virt ? s[0] : s[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_step();
    logic [63:0] nc;
    logic [5:0]  ns;
    logic        wr_c, wr_s, wrap, any;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      nc = m_cnt[i]; ns = m_sel[i]; wrap = 1'b0;
      if (usable(i)) begin
        wr_c = wr_en && (wr_idx == 3'(i)) && !wr_kind[1];
        wr_s = wr_en && (wr_idx == 3'(i)) &&
               ((wr_kind == 2'd2 && !mode32) || (wr_kind == 2'd3 && mode32));
        if (inc[i] && !inhibit[i] && !filt(m_sel[i]) && !wr_c) begin
          if (mode32) begin
            if (nc[31:0] == 32'hFFFF_FFFF) begin
              if (nc[63:32] == 32'hFFFF_FFFF) begin nc = '0; wrap = 1'b1; end
              else nc[63:32] = nc[63:32] + 32'd1;
            end else nc[31:0] = nc[31:0] + 32'd1;
          end else if (nc == ONES) begin nc = '0; wrap = 1'b1; end
          else nc = nc + 64'd1;
        end
        if (wr_c) begin
          if (wr_kind == 2'd0) begin
            if (mode32) nc[31:0] = wr_data[31:0]; else nc = wr_data;
          end else nc[63:32] = wr_data[31:0];
        end
        if (wr_s) ns = mode32 ? wr_data[31:26] : wr_data[63:58];
        if (wrap && !m_sel[i][5]) begin ns[5] = 1'b1; any = 1'b1; end
      end
      m_cnt[i] = nc; m_sel[i] = ns;
    end
    m_irq = any | (m_irq & ~irq_clr);
  endtask

  task automatic chk(string tag, bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < N; i++) begin
      rd_idx = 3'(i);
      #0.5;
      chk(tag, rd_cnt === m_cnt[i], $sformatf("count[%0d]", i), rd_cnt, m_cnt[i]);
      chk(tag, rd_sel === m_sel[i], $sformatf("sel[%0d]", i), 64'(rd_sel), 64'(m_sel[i]));
    end
    chk(tag, irq === m_irq, "irq", 64'(irq), 64'(m_irq));
  endtask

  // Applied inputs are latched at the next edge; model follows, outputs compared at negedge.
  task automatic cycle(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle();
    inc = '0; wr_en = 1'b0; irq_clr = 1'b0; inhibit = '0;
  endtask

  task automatic wr(string tag, logic [1:0] k, logic [2:0] idx, logic [63:0] d);
    wr_en = 1'b1; wr_kind = k; wr_idx = idx; wr_data = d;
    cycle(tag);
    wr_en = 1'b0;
  endtask

  task automatic see(string tag, logic [2:0] idx, logic [63:0] exp_cnt);
    rd_idx = idx;
    #0.5;
    chk(tag, rd_cnt === exp_cnt, "directed count", rd_cnt, exp_cnt);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
    m_irq = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1");
    chk("R1", irq === 1'b0, "irq after reset", 64'(irq), 64'd0);

    // R2: plain counting in machine mode
    inc = 8'h08;
    repeat (5) cycle("R2");
    idle(); cycle("R2");
    see("R2", 3'd3, 64'd5);

    // R3: inhibit bit, fixed and unavailable indices
    inhibit = 8'h08; inc = 8'hFF; cycle("R3");
    see("R3", 3'd3, 64'd5);
    idle();
    wr("R3", 2'd0, 3'd1, 64'h1234);
    wr("R3", 2'd0, 3'd6, 64'h1234);
    see("R3", 3'd6, 64'd0);

    // R4: each filter bit against each mode
    for (int b = 0; b < 5; b++) begin
      wr("R4", 2'd2, 3'd4, 64'(1) << (58 + b));
      for (int m = 0; m < 5; m++) begin
        case (m)
          0: begin priv = 2'd3; virt = 1'b0; end
          1: begin priv = 2'd1; virt = 1'b0; end
          2: begin priv = 2'd0; virt = 1'b0; end
          3: begin priv = 2'd1; virt = 1'b1; end
          default: begin priv = 2'd0; virt = 1'b1; end
        endcase
        inc = 8'h10; cycle("R4"); idle();
      end
    end
    priv = 2'd2; inc = 8'h10; cycle("R4"); idle();
    priv = 2'd3; virt = 1'b0;
    wr("R4", 2'd2, 3'd4, 64'd0);

    // R5: 64-bit wrap
    wr("R5", 2'd0, 3'd5, ONES);
    inc = 8'h20; cycle("R5"); idle();
    see("R5", 3'd5, 64'd0);
    chk("R5", irq === 1'b1, "irq after wrap", 64'(irq), 64'd1);

    // R9 / R6: clear request, wrap again with flag still set
    irq_clr = 1'b1; cycle("R9"); idle();
    chk("R9", irq === 1'b0, "irq after clear", 64'(irq), 64'd0);
    wr("R6", 2'd0, 3'd5, ONES);
    inc = 8'h20; cycle("R6"); idle(); cycle("R6");
    chk("R6", irq === 1'b0, "irq on second wrap", 64'(irq), 64'd0);
    wr("R9", 2'd2, 3'd5, 64'd0);
    wr("R9", 2'd0, 3'd5, ONES);
    inc = 8'h20; irq_clr = 1'b1; cycle("R9"); idle();
    chk("R9", irq === 1'b1, "set beats clear", 64'(irq), 64'd1);
    irq_clr = 1'b1; cycle("R9"); idle();

    // R10: write beats increment
    inc = 8'h08; wr("R10", 2'd0, 3'd3, 64'h77);
    idle(); see("R10", 3'd3, 64'h77);

    // R11 / R7: 32-bit view
    mode32 = 1'b1;
    wr("R11", 2'd0, 3'd7, 64'hAAAA_AAAA_FFFF_FFFF);
    wr("R11", 2'd1, 3'd7, 64'h0000_0000_0000_0005);
    see("R11", 3'd7, 64'h0000_0005_FFFF_FFFF);
    inc = 8'h80; cycle("R7"); idle();
    see("R7", 3'd7, 64'h0000_0006_FFFF_FFFF);
    wr("R7", 2'd1, 3'd7, 64'hFFFF_FFFF);
    inc = 8'h80; cycle("R7"); idle();
    see("R7", 3'd7, 64'd0);
    inc = 8'h80; cycle("R7"); idle();
    see("R7", 3'd7, 64'd1);

    // R8: selector placement per mode
    wr("R8", 2'd2, 3'd3, 64'hFC00_0000_0000_0000);
    wr("R8", 2'd3, 3'd3, 64'h0000_0000_8000_0000);
    mode32 = 1'b0;
    wr("R8", 2'd3, 3'd3, 64'h0000_0000_7C00_0000);
    wr("R8", 2'd2, 3'd3, 64'd0);
    irq_clr = 1'b1; cycle("R9"); idle();

    // Random mix in both views
    for (int c = 0; c < 1200; c++) begin
      if (c % 150 == 0) mode32 = $urandom_range(1, 0) == 1;
      inc     = 8'($urandom);
      inhibit = 8'($urandom) & 8'($urandom) & 8'($urandom);
      case ($urandom_range(3, 0))
        0: priv = 2'd0; 1: priv = 2'd1; 2: priv = 2'd3;
        default: priv = 2'($urandom);
      endcase
      virt    = $urandom_range(1, 0) == 1;
      irq_clr = $urandom_range(7, 0) == 0;
      wr_en   = $urandom_range(4, 0) == 0;
      wr_kind = 2'($urandom);
      wr_idx  = 3'($urandom);
      case ($urandom_range(4, 0))
        0: wr_data = ONES - 64'($urandom_range(3, 0));
        1: wr_data = {32'hFFFF_FFFF, 32'hFFFF_FFFF - 32'($urandom_range(3, 0))};
        2: wr_data = {$urandom, $urandom} & 64'h0300_0000_0300_0000;
        3: wr_data = 64'($urandom_range(3, 0));
        default: wr_data = {$urandom, $urandom};
      endcase
      cycle("R2/R4");
    end
    idle();
    cycle("R2/R4");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule